// File: doc/BRIEF.md
# Programmable Timer/Event Counter with Buffered Byte Access

This block is a 16-bit up-counter that sits on a byte-wide processor register bus. Software picks one of three ways for it to advance. It can count edges on an external input pin, count ticks of an internal clock-enable, or time a single pulse on the pin using the internal tick. When the count passes its all-ones value, the counter reloads from a 16-bit preload register and raises an overflow interrupt flag. The flag stays set until software pulses a clear strobe.

The 16-bit values cross the 8-bit bus through one shared low-byte buffer, which keeps a pair of byte accesses coherent:
- A low-byte write only fills the buffer.
- A high-byte write commits the written byte and the buffered byte to the preload in one step.
- A high-byte read returns the live high byte and, in the same access, captures the live low byte into the buffer. A later low-byte read returns that captured byte, so the two bytes always belong to one count value.

Pulse-width mode is one-shot. It arms on the chosen edge and counts ticks while the pin stays at the new level. When the pin returns, hardware clears the enable bit. The result then stays in the counter until software enables the counter again.

The bus has no back-pressure. A read strobe always produces its data one clock later, flagged by a one-cycle read-valid pulse, and a write strobe always takes effect at the clock edge where it is sampled. The pin passes through a two-flop synchronizer before edge detection, so pin activity reaches the counter two clocks late.

Top module: `tmr_evctr`

## Requirements
- R1: After reset the counter, the preload, the low-byte buffer, the control register and the overflow flag are all zero. Reads of the high byte, low byte and control all return 0, and no counting happens.
- R2: A write to the low-byte address (addr 0) changes only the low-byte buffer. A following low-byte read returns the written byte. The counter and the preload are unchanged.
- R3: A write to the high-byte address (addr 1) loads the preload with {written byte, buffered low byte}. Every such write updates the preload.
- R4: A read of addr 1 returns counter[15:8] and, in the same access, copies counter[7:0] into the buffer. A later read of addr 0 returns that copied byte even if the counter has moved since. Read data appears on bus_rdata with bus_rvalid high one clock after the read strobe.
- R5: The control register (addr 2) holds the mode in bits [1:0] (00 stopped, 01 event count, 10 timer, 11 pulse width), the edge bit in bit 2 (1 selects rising, 0 selects falling) and the enable bit in bit 3. It reads back as {4'b0, enable, edge, mode}.
- R6: In timer mode with enable set, the counter increments once for each clock in which tick is high. With enable clear, or with mode 00, the counter holds.
- R7: In event mode with enable set, the counter increments once per synchronized pin edge of the selected polarity. Edges of the other polarity and the tick input have no effect.
- R8: When an increment would pass FFFFh, the counter loads the preload and the overflow flag sets. The flag stays set until a cycle with irq_clr high.
- R9: In pulse-width mode with enable set, a rising pin edge (edge bit 1) starts the measurement. The counter then adds one per tick until the pin falls, and at that point hardware clears the enable bit. With tick held high, a pulse W clocks wide adds exactly W.
- R10: With edge bit 0, pulse-width mode measures a low pulse, starting at a falling edge and stopping at the next rising edge.
- R11: After a measurement completes, further pin edges leave the counter and the control register unchanged until software sets the enable bit again.
- R12: An overflow during a pulse-width measurement reloads from the preload and sets the flag, and counting continues from the reloaded value until the pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Pulses one clock after a read strobe |
| ext_pin | input | 1 | External event / pulse input, asynchronous |
| tick | input | 1 | Internal count enable, one clock wide per tick |
| irq_clr | input | 1 | Clears the overflow flag |
| ovf_irq | output | 1 | Overflow interrupt flag |

## Verification
The hardest situation to reach from the ports is an overflow in the middle of a pulse-width measurement. The pulse has to start with the counter only a few counts below FFFFh, and the preload has to hold a value different from the reload used before. The stimulus first runs timer mode through a full 16-bit wrap so the counter lands just below the top. It then loads a new preload and writes a trailing low byte that must not disturb that preload. Finally it times pulses of known width until one crosses FFFFh. The expected result is a reload followed by further counting, all derived from the pulse width in clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int CTRL_EN_BIT  = 3;
  localparam int CTRL_POL_BIT = 2;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_rise,
  output logic pin_fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pin_async;
  end

  // Remaining synchronizer stages
  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign pin_rise = chain_q[STAGES-1] & ~prev_q;
  assign pin_fall = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic [CNT_W-1:0] count,
  input  logic             hw_clr_en,
  output logic [CNT_W-1:0] preload,
  output mode_e            mode,
  output logic             pol_rise,
  output logic             enable
);

  logic [BUS_W-1:0] lo_buf_q;
  logic [BUS_W-1:0] rdata_q;
  logic             rvalid_q;
  logic [BUS_W-1:0] rd_mux;
  logic             wr_lo, wr_hi, wr_ctrl, rd_hi;
  logic             unused_wbits;

  assign wr_lo   = bus_wr && (bus_addr == ADDR_LO);
  assign wr_hi   = bus_wr && (bus_addr == ADDR_HI);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_hi   = bus_rd && (bus_addr == ADDR_HI);
  assign unused_wbits = ^bus_wdata[BUS_W-1:4];

  // Low-byte buffer: filled by low writes and by high reads
  always_ff @(posedge clk) begin
    if (!rst_n)      lo_buf_q <= '0;
    else if (wr_lo)  lo_buf_q <= bus_wdata;
    else if (rd_hi)  lo_buf_q <= count[BUS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     preload <= '0;
    else if (wr_hi) preload <= {bus_wdata, lo_buf_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_OFF;
      pol_rise <= 1'b0;
      enable   <= 1'b0;
    end else if (wr_ctrl) begin
      mode     <= mode_e'(bus_wdata[1:0]);
      pol_rise <= bus_wdata[CTRL_POL_BIT];
      enable   <= bus_wdata[CTRL_EN_BIT];
    end else if (hw_clr_en) begin
      enable   <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_LO:   rd_mux = lo_buf_q;
      ADDR_HI:   rd_mux = count[CNT_W-1:BUS_W];
      ADDR_CTRL: rd_mux = {{(BUS_W-4){1'b0}}, enable, pol_rise, mode};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  logic             pol_rise,
  input  logic             enable,
  input  logic [CNT_W-1:0] preload,
  input  logic             tick,
  input  logic             pin_rise,
  input  logic             pin_fall,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count,
  output logic             hw_clr_en,
  output logic             ovf_irq
);

  logic trig_edge, back_edge;
  logic measuring_q;
  logic inc, wrap;

  assign trig_edge = pol_rise ? pin_rise : pin_fall;
  assign back_edge = pol_rise ? pin_fall : pin_rise;

  // One-shot pulse measurement state
  always_ff @(posedge clk) begin
    if (!rst_n)                                measuring_q <= 1'b0;
    else if (!(enable && mode == MODE_PULSE))  measuring_q <= 1'b0;
    else if (!measuring_q && trig_edge)        measuring_q <= 1'b1;
    else if (measuring_q && back_edge)         measuring_q <= 1'b0;
  end

  assign hw_clr_en = enable && (mode == MODE_PULSE) && measuring_q && back_edge;

  always_comb begin
    inc = 1'b0;
    if (enable) begin
      case (mode)
        MODE_EVENT: inc = trig_edge;
        MODE_TIMER: inc = tick;
        MODE_PULSE: inc = measuring_q && tick;
        default:    inc = 1'b0;
      endcase
    end
  end

  assign wrap = inc && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (wrap) count <= preload;
    else if (inc)  count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_irq <= 1'b0;
    else if (wrap)    ovf_irq <= 1'b1;
    else if (irq_clr) ovf_irq <= 1'b0;
  end

endmodule

// File: rtl/tmr_evctr.sv
module tmr_evctr
  import tmr_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic             ext_pin,
  input  logic             tick,
  input  logic             irq_clr,
  output logic             ovf_irq
);

  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] preload;
  mode_e            mode;
  logic             pol_rise, enable, hw_clr_en;
  logic             pin_rise, pin_fall;

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_pin),
    .pin_rise  (pin_rise),
    .pin_fall  (pin_fall)
  );

  tmr_regs #(.BUS_W(BUS_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .count      (count),
    .hw_clr_en  (hw_clr_en),
    .preload    (preload),
    .mode       (mode),
    .pol_rise   (pol_rise),
    .enable     (enable)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .pol_rise  (pol_rise),
    .enable    (enable),
    .preload   (preload),
    .tick      (tick),
    .pin_rise  (pin_rise),
    .pin_fall  (pin_fall),
    .irq_clr   (irq_clr),
    .count     (count),
    .hw_clr_en (hw_clr_en),
    .ovf_irq   (ovf_irq)
  );

endmodule

// File: rtl/tmr_evctr_chk.sv
module tmr_evctr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             irq_clr,
  input logic             ovf_irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] preload,
  input logic [1:0]       mode,
  input logic             enable
);

  // R2
  lo_write_keeps_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> $stable(preload));

  // R6
  disabled_count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> $stable(count));

  // R8
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == {CNT_W{1'b1}}) |=> (count == {CNT_W{1'b1}}) || ovf_irq);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && !irq_clr) |=> ovf_irq);

  // R9
  hw_clear_only_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(enable) && !$past(bus_wr && bus_addr == 2'd2)) |-> ($past(mode) == 2'b11));

endmodule

bind tmr_evctr tmr_evctr_chk #(.CNT_W(2 * BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .irq_clr  (irq_clr),
  .ovf_irq  (ovf_irq),
  .count    (count),
  .preload  (preload),
  .mode     (mode),
  .enable   (enable)
);

// File: tb/test_tmr_evctr.sv
module test_tmr_evctr;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic       ext_pin = 1'b0;
  logic       tick = 1'b0;
  logic       irq_clr = 1'b0;
  logic       ovf_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_evctr i_tmr_evctr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ext_pin(ext_pin), .tick(tick), .irq_clr(irq_clr), .ovf_irq(ovf_irq)
  );

  // Monitor: pops the expected byte of each read response
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read response actual=%02h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s read actual=%02h expected=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_count(input logic [15:0] e, input string t);
    bus_read(2'd1, e[15:8], t);
    bus_read(2'd0, e[7:0], t);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pin_pulse(input logic lvl, input int width);
    @(negedge clk);
    ext_pin = lvl;
    repeat (width) @(negedge clk);
    ext_pin = ~lvl;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_flag(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (ovf_irq !== e) begin
      failures++;
      $display("FAIL %s flag actual=%0b expected=%0b", t, ovf_irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      checks++;
      if (exp_q.size() != 0) begin
        failures++;
        $display("FAIL read responses missing actual=0 expected=%0d", exp_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_flag(1'b0, "R1");
    bus_read(2'd2, 8'h00, "R1 ctrl");
    read_count(16'h0000, "R1 count");

    // R2 low write fills buffer only
    bus_write(2'd0, 8'h5A);
    bus_read(2'd0, 8'h5A, "R2 buffer");
    read_count(16'h0000, "R2 count unchanged");

    // R5 control readback, R6 timer counting
    bus_write(2'd2, 8'h0A);
    bus_read(2'd2, 8'h0A, "R5 ctrl");
    ticks(300);
    bus_write(2'd2, 8'h02);
    ticks(20);                         // R6 disabled: no change
    read_count(16'h012C, "R6 timer");
    bus_write(2'd2, 8'h08);
    ticks(10);                         // R6 mode 00 stopped
    read_count(16'h012C, "R6 stopped");

    // R4 coherent high/low read while counting
    bus_write(2'd2, 8'h0A);
    ticks(5);                          // count 0x0131
    bus_read(2'd1, 8'h01, "R4 hi");
    ticks(10);                         // count 0x013B
    bus_read(2'd0, 8'h31, "R4 latched lo");
    bus_write(2'd2, 8'h02);
    read_count(16'h013B, "R4 after");

    // R7 event mode, rising then falling, tick held high
    tick = 1'b1;
    bus_write(2'd2, 8'h0D);
    for (int i = 0; i < 4; i++) pin_pulse(1'b1, 4);
    bus_write(2'd2, 8'h09);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) pin_pulse(1'b1, 3);
    bus_write(2'd2, 8'h01);
    tick = 1'b0;
    read_count(16'h0142, "R7 event");

    // R3 preload FFF0, R8 overflow after full wrap
    bus_write(2'd0, 8'hF0);
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'h0A);
    ticks(16'hFFFF - 16'h0142);        // count FFFF
    check_flag(1'b0, "R8 before wrap");
    bus_write(2'd2, 8'h02);
    read_count(16'hFFFF, "R8 top");
    bus_write(2'd2, 8'h0A);
    ticks(1);
    bus_write(2'd2, 8'h02);
    read_count(16'hFFF0, "R3 reload");
    check_flag(1'b1, "R8 set");
    repeat (5) @(negedge clk);
    check_flag(1'b1, "R8 held");
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check_flag(1'b0, "R8 cleared");

    // R9 pulse-width, high pulse of 7 clocks
    tick = 1'b1;
    bus_write(2'd2, 8'h0F);
    pin_pulse(1'b1, 7);
    tick = 1'b0;
    bus_read(2'd2, 8'h07, "R9 enable cleared");
    read_count(16'hFFF7, "R9 width");

    // R11 further edges ignored
    tick = 1'b1;
    pin_pulse(1'b1, 5);
    pin_pulse(1'b1, 5);
    tick = 1'b0;
    read_count(16'hFFF7, "R11 held");
    bus_read(2'd2, 8'h07, "R11 ctrl");

    // R10 low pulse of 5 clocks
    @(negedge clk); ext_pin = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b1;
    bus_write(2'd2, 8'h0B);
    pin_pulse(1'b0, 5);
    tick = 1'b0;
    bus_read(2'd2, 8'h03, "R10 enable cleared");
    read_count(16'hFFFC, "R10 width");

    // R12 overflow inside a measurement; trailing low write must not touch preload
    bus_write(2'd0, 8'h34);
    bus_write(2'd1, 8'h12);
    bus_write(2'd0, 8'h99);
    @(negedge clk); ext_pin = 1'b0;
    repeat (5) @(negedge clk);
    tick = 1'b1;
    bus_write(2'd2, 8'h0F);
    pin_pulse(1'b1, 9);
    tick = 1'b0;
    read_count(16'h1239, "R12 reload mid pulse");
    check_flag(1'b1, "R12 flag");
    bus_read(2'd2, 8'h07, "R12 ctrl");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule